// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the slot control and slot status halves of a PCI Express port capability, and it sits behind a simple register bus. Each access carries a dword offset inside the capability, four byte enables and 32 bits of write data. Reads return the addressed dword combinationally. Software uses the control half to drive the power and attention indicators and to choose which slot events may interrupt. The status half gathers those events as sticky bits, and software clears each one by writing a one to it.

Platform logic reports slot events through single-cycle set pulses: attention button, power fault, presence change, presence state and link-state change. When software switches the power indicator to Off while a device is present, the block treats the write as a surprise removal. It drops presence state, records a presence change, raises a removal flag and evaluates the hot-plug interrupt. Any control write that changes the stored value also performs the command-completed handshake. An interrupt request leaves the block as a one-cycle pulse, and only while the external message-interrupt enable is high.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset, slot control holds 0x03C0, which puts both indicators Off. Slot status holds 0, and `irq_req` and `removal_flag` are low.
- R2: A read at dword offset 6 returns status in bits 31:16 and control in bits 15:0. A read at any other offset returns 0.
- R3: A control write is accepted only at offset 6 with byte enables 4'b0011. Any other byte-enable pattern at that offset leaves control unchanged.
- R4: A control write is a removal when three conditions hold: status bit 6 (presence state) is 1, the new bits 9:8 (power indicator) are 2'b11 (Off), and the old bits 9:8 are not 2'b11. A removal clears bit 6 and sets bit 3 (presence changed). Any other control write leaves bits 6 and 3 unchanged.
- R5: A control write whose value differs from the stored control sets status bit 4 (command completed). A write of the same value does not set it.
- R6: A control write that sets bit 4 raises a command-completed interrupt when control bit 4 (command-completed enable) is set.
- R7: A removal raises a hot-plug interrupt when two conditions hold: control bit 5 (hot-plug enable) is 1, and status AND control AND 0x0009 is nonzero. In that mask, bit 0 is the attention-button enable and status bit, and bit 3 is the presence-changed enable and status bit.
- R8: Status bits 0, 1, 3, 4 and 8 clear when a one is written to them, and writing zero leaves them unchanged. Bit 6 cannot be cleared by a write. The set pulses `ev_attn_btn`, `ev_pwr_fault`, `ev_pres_chg`, `ev_pres_state` and `ev_link_chg` set bits 0, 1, 3, 6 and 8 respectively.
- R9: `removal_flag` is updated on every write whose offset is below 15. It shows whether that write was a removal. A write at offset 15 leaves it unchanged.
- R10: `irq_req` is high for exactly the one cycle after the clock edge that takes the interrupting write, and only when `msi_en` is high during that write.
- R11: When a set pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R12: A status write is accepted only at offset 6 with byte enables 4'b1100, and the data is taken from bits 31:16. Any other pattern leaves status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_en | input | 1 | Message-interrupt enable gating the request |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Dword offset inside the capability |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_attn_btn | input | 1 | Attention-button set pulse |
| ev_pwr_fault | input | 1 | Power-fault set pulse |
| ev_pres_chg | input | 1 | Presence-changed set pulse |
| ev_pres_state | input | 1 | Presence-state set pulse |
| ev_link_chg | input | 1 | Link-state-changed set pulse |
| irq_req | output | 1 | One-cycle interrupt request |
| removal_flag | output | 1 | Last capability write was a removal |

## Verification
The hardest case to reach from the ports is a removal write whose hot-plug interrupt depends on the three-way AND of status, control and the enable mask. Reaching it takes several preparation steps in order:
- raise presence state with a set pulse;
- program a control value with the power indicator on;
- clear the command-completed bit left behind by that write;
- write the Off value.

Each enable combination is built this way so that the interrupt is seen both firing and held back. A second hard case is a set pulse and a clear on the same bit in the same cycle. The bench reaches it by pulsing the event input inside the cycle that carries the status write.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int STA_ABP   = 0;
  localparam int STA_PFD   = 1;
  localparam int STA_PDC   = 3;
  localparam int STA_CC    = 4;
  localparam int STA_PDS   = 6;
  localparam int STA_DLLSC = 8;

  localparam int CTL_ABPE  = 0;
  localparam int CTL_PDCE  = 3;
  localparam int CTL_CCIE  = 4;
  localparam int CTL_HPIE  = 5;
  localparam int AIND_LO   = 6;
  localparam int PIND_LO   = 8;

  localparam logic [1:0]  IND_OFF  = 2'b11;
  localparam logic [15:0] W1C_MASK = (16'd1 << STA_ABP) | (16'd1 << STA_PFD) |
                                     (16'd1 << STA_PDC) | (16'd1 << STA_CC)  |
                                     (16'd1 << STA_DLLSC);
  localparam logic [15:0] HP_MASK  = (16'd1 << CTL_ABPE) | (16'd1 << CTL_PDCE);
  localparam logic [15:0] CTL_RST  = (16'(IND_OFF) << PIND_LO) | (16'(IND_OFF) << AIND_LO);

  function automatic logic pwr_off(input logic [15:0] ctl);
    return ctl[PIND_LO +: 2] == IND_OFF;
  endfunction

  function automatic logic is_removal(input logic pds, input logic [15:0] nctl,
                                      input logic [15:0] octl);
    return pds && pwr_off(nctl) && !pwr_off(octl);
  endfunction

  function automatic logic hp_fire(input logic [15:0] sta, input logic [15:0] ctl);
    return ctl[CTL_HPIE] && ((sta & ctl & HP_MASK) != 16'd0);
  endfunction

  function automatic logic cc_fire(input logic [15:0] sta, input logic [15:0] ctl);
    return ctl[CTL_CCIE] && sta[STA_CC];
  endfunction

  function automatic logic [15:0] w1c(input logic [15:0] cur, input logic [15:0] wv);
    return cur & ~(wv & W1C_MASK);
  endfunction
endpackage

// File: rtl/hp_slot_decode.sv
module hp_slot_decode #(
  parameter int ADDR_W     = 4,
  parameter int CAP_DWORDS = 15,
  parameter int SLOT_DW    = 6
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic              cap_wr,
  output logic              ctl_sel,
  output logic              sta_sel,
  output logic              slot_hit
);
  localparam logic [ADDR_W-1:0] SLOT_A  = ADDR_W'(SLOT_DW);
  localparam logic [ADDR_W:0]   CAP_LIM = (ADDR_W+1)'(CAP_DWORDS);

  assign slot_hit = (addr == SLOT_A);
  assign cap_wr   = wr && ({1'b0, addr} < CAP_LIM);
  assign ctl_sel  = wr && slot_hit && (be == 4'b0011);
  assign sta_sel  = wr && slot_hit && (be == 4'b1100);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter bit SLOT_IMPL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [15:0] wdata,
  output logic [15:0] ctl_q
);
  generate
    if (SLOT_IMPL) begin : g_impl
      logic [15:0] ctl_r;
      always_ff @(posedge clk) begin
        if (!rst_n)      ctl_r <= CTL_RST;
        else if (ctl_wr) ctl_r <= wdata;
      end
      assign ctl_q = ctl_r;

      // R3: without an accepted write, control holds
      p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ctl_q));
    end else begin : g_none
      assign ctl_q = 16'd0;
    end
  endgenerate
endmodule

// File: rtl/hp_slot_status.sv
module hp_slot_status
  import hp_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [15:0] new_ctl,
  input  logic [15:0] old_ctl,
  input  logic        sta_wr,
  input  logic [15:0] sta_wv,
  input  logic [15:0] set_vec,
  output logic [15:0] sta_q,
  output logic [15:0] sta_next,
  output logic        removal_evt,
  output logic        cc_evt
);
  assign removal_evt = ctl_wr && is_removal(sta_q[STA_PDS], new_ctl, old_ctl);
  assign cc_evt      = ctl_wr && (new_ctl != old_ctl);

  always_comb begin
    sta_next = sta_q;
    if (sta_wr) sta_next = w1c(sta_next, sta_wv);
    if (removal_evt) begin
      sta_next[STA_PDS] = 1'b0;
      sta_next[STA_PDC] = 1'b1;
    end
    if (cc_evt) sta_next[STA_CC] = 1'b1;
    sta_next = sta_next | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sta_q <= 16'd0;
    else        sta_q <= sta_next;
  end

  // R4: removal drops presence state and records the change
  p_removal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    removal_evt && !set_vec[STA_PDS] |=> !sta_q[STA_PDS] && sta_q[STA_PDC]);
  // R8: one written to attention bit clears it
  p_w1c_abp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sta_wr && sta_wv[STA_ABP] && !set_vec[STA_ABP] |=> !sta_q[STA_ABP]);
  // R11: set pulses always land
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 16'd0) |=> ((sta_q & $past(set_vec)) == $past(set_vec)));
  // R12: no access and no event keeps status steady
  p_sta_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sta_wr && !ctl_wr && (set_vec == 16'd0) |=> $stable(sta_q));
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter bit SLOT_IMPL  = 1'b1,
  parameter int ADDR_W     = 4,
  parameter int CAP_DWORDS = 15,
  parameter int SLOT_DW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_attn_btn,
  input  logic              ev_pwr_fault,
  input  logic              ev_pres_chg,
  input  logic              ev_pres_state,
  input  logic              ev_link_chg,
  output logic              irq_req,
  output logic              removal_flag
);
  logic        cap_wr, ctl_sel, sta_sel, slot_hit;
  logic        ctl_wr_eff, sta_wr_eff;
  logic [15:0] ctl_q, sta_q, sta_next, set_vec;
  logic        removal_evt, cc_evt, irq_fire;
  logic        irq_q, removal_q;

  hp_slot_decode #(.ADDR_W(ADDR_W), .CAP_DWORDS(CAP_DWORDS), .SLOT_DW(SLOT_DW)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .be(bus_be),
    .cap_wr(cap_wr), .ctl_sel(ctl_sel), .sta_sel(sta_sel), .slot_hit(slot_hit)
  );

  assign ctl_wr_eff = ctl_sel && SLOT_IMPL;
  assign sta_wr_eff = sta_sel && SLOT_IMPL;

  always_comb begin
    set_vec            = 16'd0;
    set_vec[STA_ABP]   = ev_attn_btn;
    set_vec[STA_PFD]   = ev_pwr_fault;
    set_vec[STA_PDC]   = ev_pres_chg;
    set_vec[STA_PDS]   = ev_pres_state;
    set_vec[STA_DLLSC] = ev_link_chg;
  end

  hp_slot_ctrl #(.SLOT_IMPL(SLOT_IMPL)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr_eff),
    .wdata(bus_wdata[15:0]), .ctl_q(ctl_q)
  );

  hp_slot_status u_sta (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr_eff),
    .new_ctl(bus_wdata[15:0]), .old_ctl(ctl_q),
    .sta_wr(sta_wr_eff), .sta_wv(bus_wdata[31:16]), .set_vec(set_vec),
    .sta_q(sta_q), .sta_next(sta_next),
    .removal_evt(removal_evt), .cc_evt(cc_evt)
  );

  assign irq_fire = msi_en &&
    ((removal_evt && hp_fire(sta_next, bus_wdata[15:0])) ||
     (cc_evt && cc_fire(sta_next, bus_wdata[15:0])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      removal_q <= 1'b0;
    end else begin
      irq_q <= irq_fire;
      if (cap_wr) removal_q <= removal_evt;
    end
  end

  assign bus_rdata    = slot_hit ? {sta_q, ctl_q} : 32'd0;
  assign irq_req      = irq_q;
  assign removal_flag = removal_q;

  // R10: a request follows only a control write made while enabled
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(msi_en) && $past(ctl_wr_eff));
  // R10: no control write, no request in the following cycle
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_eff |=> !irq_req);
  // R9: a non-removal capability write lowers the flag
  p_rm_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_wr && !removal_evt |=> !removal_flag);
  // R5: a changing control write leaves command completed set
  p_cc_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_evt |=> sta_q[STA_CC]);
endmodule

// File: tb/hp_slot_regs_test.sv
`timescale 1ns/100ps
module hp_slot_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_en = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [3:0]  bus_be = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [4:0]  ev = 5'd0; // {link, pres_state, pres_chg, fault, attn}
  logic        irq_req, removal_flag;
  int          checks = 0, errors = 0;
  logic        irq_s, rem_s;

  always #2.5 clk = ~clk;

  hp_slot_regs uut (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ev_attn_btn(ev[0]), .ev_pwr_fault(ev[1]),
    .ev_pres_chg(ev[2]), .ev_pres_state(ev[3]), .ev_link_chg(ev[4]),
    .irq_req(irq_req), .removal_flag(removal_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d,
                    input logic [4:0] e = 5'd0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d; ev = e;
    @(posedge clk); #1;
    irq_s = irq_req; rem_s = removal_flag;
    @(negedge clk);
    bus_wr = 1'b0; ev = 5'd0;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = 5'd0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wctl(input logic [15:0] v); wr(4'd6, 4'b0011, {16'd0, v}); endtask
  task automatic clr_sta; wr(4'd6, 4'b1100, 32'hFFFF_0000); endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'd0, irq_req}, 0);
    chk("R1 removal", {31'd0, removal_flag}, 0);
    rd(4'd6, d); chk("R1/R2 slot dword", d, 32'h0000_03C0);
    rd(4'd2, d); chk("R2 other offset", d, 0);
  endtask

  task automatic t_size;
    logic [31:0] d;
    wr(4'd6, 4'b1111, 32'h0000_0000); rd(4'd6, d); chk("R3 dword write ignored", d, 32'h03C0);
    wr(4'd6, 4'b0001, 32'h0000_0000); rd(4'd6, d); chk("R3 byte write ignored", d, 32'h03C0);
    chk("R3 no irq", {31'd0, irq_s}, 0);
  endtask

  task automatic t_cc;
    logic [31:0] d;
    wctl(16'h03D0);
    chk("R6/R10 cc irq", {31'd0, irq_s}, 1);
    @(posedge clk); #1; chk("R10 single cycle", {31'd0, irq_req}, 0);
    rd(4'd6, d); chk("R5 cc set", d, 32'h0010_03D0);
    clr_sta; rd(4'd6, d); chk("R12 w1c cc", d, 32'h0000_03D0);
    wctl(16'h03D0); rd(4'd6, d); chk("R5 same value no cc", d, 32'h0000_03D0);
    chk("R5 same value no irq", {31'd0, irq_s}, 0);
    msi_en = 1'b0;
    wctl(16'h03D1); chk("R10 gated by msi_en", {31'd0, irq_s}, 0);
    rd(4'd6, d); chk("R5 cc set while gated", d, 32'h0010_03D1);
    msi_en = 1'b1;
  endtask

  task automatic t_removal;
    logic [31:0] d;
    pulse(5'b01000);
    wctl(16'h0139); clr_sta;
    rd(4'd6, d); chk("R8 pds kept by w1c", d, 32'h0040_0139);
    wctl(16'h0329);
    chk("R7 hp irq on removal", {31'd0, irq_s}, 1);
    chk("R4 removal flag", {31'd0, rem_s}, 1);
    rd(4'd6, d); chk("R4 status after removal", d, 32'h0018_0329);
    wr(4'd15, 4'b1111, 32'h0); chk("R9 offset 15 keeps flag", {31'd0, rem_s}, 1);
    wr(4'd0, 4'b1111, 32'h0); chk("R9 flag cleared", {31'd0, rem_s}, 0);
    wctl(16'h0129); clr_sta; wctl(16'h0329);
    chk("R4 no removal without pds", {31'd0, rem_s}, 0);
    rd(4'd6, d); chk("R4 pdc untouched", d, 32'h0010_0329);
  endtask

  task automatic t_hp_mask;
    pulse(5'b01000); clr_sta;
    wctl(16'h0100); wctl(16'h0300);
    chk("R4 removal w/o hpie", {31'd0, rem_s}, 1);
    chk("R7 no irq w/o hpie", {31'd0, irq_s}, 0);
    pulse(5'b01000); clr_sta;
    wctl(16'h0120); wctl(16'h0320);
    chk("R7 no irq with masks off", {31'd0, irq_s}, 0);
    pulse(5'b01001); wctl(16'h0121);
    chk("R7 no irq without removal", {31'd0, irq_s}, 0);
    wctl(16'h0321);
    chk("R7 irq via attention button", {31'd0, irq_s}, 1);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    clr_sta; pulse(5'b11111);
    rd(4'd6, d); chk("R8 set pulses", d[31:16], 32'h014B);
    wr(4'd6, 4'b1100, 32'h0); rd(4'd6, d); chk("R8 zero write keeps", d[31:16], 32'h014B);
    wr(4'd6, 4'b1111, 32'hFFFF_0000); rd(4'd6, d); chk("R12 wrong size ignored", d[31:16], 32'h014B);
    clr_sta; rd(4'd6, d); chk("R8 w1c all", d[31:16], 32'h0040);
    wr(4'd6, 4'b1100, 32'h0001_0000, 5'b00001);
    rd(4'd6, d); chk("R11 set beats clear", d[31:16], 32'h0041);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset; t_size; t_cc; t_removal; t_hp_mask; t_w1c;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule